// File: doc/BRIEF.md
# Prioritized External Chip-Select Controller

This block sits between a CPU bus and the external memory bus. For each request it decodes a 24-bit physical address. It first checks for the on-chip regions: program store, data RAM and the I/O/special-register area. On-chip regions always take precedence, and an address that falls in one is only flagged on `int_hit`. Any other address goes to one of six fixed external windows. Where windows overlap, a fixed priority picks the winner.

An external access drives one chip-select line with that select's programmed polarity, together with a read or write strobe. The strobe stretches over a programmable number of wait states. The access ends with a one-cycle ready pulse to the CPU. Each select has four programmable settings: enable, polarity, bus width (8 or 16 bits) and wait count. Software writes them one field at a time through a small configuration port. When a byte is written to a 16-bit device, the byte is copied onto both data lanes. An address that reaches no enabled window and no on-chip region completes at once and raises a bus-error pulse.

Top module: `csel_extbus_ctrl`

## Requirements
- R1: While `cpu_req` is high, `int_hit` flags the on-chip regions: bit 0 for 00_0000h–01_FFFFh, bit 1 for RAM_BASE–FF_BFFFh (default RAM_BASE FF_B000h), bit 2 for FF_E000h–FF_FFFFh. Such a request starts no external access: no strobe, no chip select, no ready, no bus error.
- R2: The external windows are fixed. Select 0 covers the whole space. Select 1 covers 80_0000h and above. Select 2 covers F0_0000h–FF_7FFFh and FF_C000h–FF_C7FFh. Selects 3, 4 and 5 each cover FF_C800h–FF_DFFFh.
- R3: When several enabled windows hold the address, only the highest-numbered one is driven. Select 5 has the highest priority and select 0 the lowest.
- R4: A disabled select is never driven and never hides a lower-priority enabled select.
- R5: `ext_cs[i]` is high when active if its polarity bit is 1, and low when active if it is 0. Its inactive level is the opposite.
- R6: The strobe (`ext_rd` or `ext_wr`) rises in the cycle after the accepted request and lasts W+1 cycles, where W is the select's 4-bit wait count. `cpu_ready` stays low for the first W strobe cycles and is high in the last one only.
- R7: `ext_addr`, the chip-select lines and `ext_dout` hold steady for the whole strobe.
- R8: Write lanes: a word on a 16-bit bus drives the full word. A byte on a 16-bit bus drives `{b,b}`, where b is `cpu_wdata[7:0]`. Any write on an 8-bit bus drives `{8'h00,b}`. `ext_doe` is high exactly while `ext_wr` is.
- R9: `cpu_rdata` takes `ext_din` as it stands in the ready cycle, and shows it from the next cycle on. A word read on a 16-bit bus returns all 16 bits. A byte read, or any read on an 8-bit bus, returns `{8'h00, ext_din[7:0]}`.
- R10: A non-internal address that matches no enabled window gives `bus_err` and `cpu_ready` together for one cycle, in the cycle after the request, with no strobe.
- R11: Configuration: on a clock edge where `cfg_we` is high and `cfg_sel` < 6, the field picked by `cfg_field` is written for select `cfg_sel`. The field codes are 0 enable, 1 polarity (1 = active high) and 2 width (1 = 16-bit), each taken from `cfg_wdata[0]`, and 3 wait count, taken from `cfg_wdata[3:0]`. After reset every select is disabled, active low and 8-bit, with wait count 15.
- R12: A request raised while an access is in progress is ignored: it neither alters the running access nor starts a new one.
- R13: At most one chip select is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration field write strobe |
| cfg_sel | input | 3 | Select being configured |
| cfg_field | input | 2 | Field code: 0 enable, 1 polarity, 2 width, 3 wait |
| cfg_wdata | input | 4 | Field value |
| cpu_req | input | 1 | Access request, one cycle |
| cpu_addr | input | 24 | Physical address |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit access, 0 = byte |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Captured read data |
| cpu_ready | output | 1 | Access-complete pulse |
| bus_err | output | 1 | Unmapped-access pulse |
| int_hit | output | 3 | On-chip region hit flags |
| ext_cs | output | 6 | Chip-select pins, polarity applied |
| ext_addr | output | 24 | External address |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_doe | output | 1 | Data output enable |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |

## Verification
Four properties are checked on every cycle: at most one select is active; the address, selects and data hold through a strobe; a ready pulse is a single cycle and closes its strobe; and bus-error and on-chip requests leave the external bus quiet. The assertions cannot see the rest. Which window wins for a given address and set of enables, the exact W+1 strobe length per select, the lane pattern on each width, the captured read value and the reset configuration are shown only by the bench, which drives a table of addresses across the window boundaries and then runs directed disable and busy scenarios.

// File: rtl/csel_pkg.sv
// Shared constants, encodings and the fixed window map of the external
// chip-select controller. Assumes a 24-bit physical address space.
package csel_pkg;
    localparam int NUM_CS = 6;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int WAIT_W = 4;
    localparam int SEL_W  = $clog2(NUM_CS);
    localparam int NUM_INT = 3;

    typedef enum logic [1:0] {
        FLD_EN   = 2'd0,
        FLD_POL  = 2'd1,
        FLD_WIDE = 2'd2,
        FLD_WAIT = 2'd3
    } cfg_field_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_e;

    // Fixed window membership of external select idx for address a.
    function automatic logic win_hit(input int idx, input logic [ADDR_W-1:0] a);
        logic r;
        case (idx)
            0:       r = 1'b1;
            1:       r = (a >= 24'h80_0000);
            2:       r = ((a >= 24'hF0_0000) && (a <= 24'hFF_7FFF)) ||
                         ((a >= 24'hFF_C000) && (a <= 24'hFF_C7FF));
            default: r = (a >= 24'hFF_C800) && (a <= 24'hFF_DFFF);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/csel_cfg_bank.sv
// Per-select configuration registers (enable, polarity, width, wait).
// Written one field per cycle; selects beyond N_CS ignore writes.
// Reset: disabled, active low, 8-bit, maximum wait.
module csel_cfg_bank
    import csel_pkg::*;
#(
    parameter int N_CS = NUM_CS,
    parameter int WW   = WAIT_W,
    parameter int SW   = SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SW-1:0]     sel,
    input  logic [1:0]        field,
    input  logic [WW-1:0]     wdata,
    output logic [N_CS-1:0]   en,
    output logic [N_CS-1:0]   pol,
    output logic [N_CS-1:0]   wide,
    output logic [N_CS*WW-1:0] wt
);
    genvar g;
    generate
        for (g = 0; g < N_CS; g++) begin : g_sel
            logic hit;
            assign hit = we && (int'(sel) == g);
            // Field registers of one select.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en[g]           <= 1'b0;
                    pol[g]          <= 1'b0;
                    wide[g]         <= 1'b0;
                    wt[g*WW +: WW]  <= '1;
                end else if (hit) begin
                    case (cfg_field_e'(field))
                        FLD_EN:   en[g]          <= wdata[0];
                        FLD_POL:  pol[g]         <= wdata[0];
                        FLD_WIDE: wide[g]        <= wdata[0];
                        FLD_WAIT: wt[g*WW +: WW] <= wdata;
                        default:  ;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/csel_decode.sv
// Address decoder: on-chip region flags, enabled window matches and
// fixed priority (highest index wins). On-chip hits suppress every
// external select. Purely combinational.
module csel_decode
    import csel_pkg::*;
#(
    parameter int               N_CS     = NUM_CS,
    parameter int               AW       = ADDR_W,
    parameter logic [AW-1:0]    RAM_BASE = 24'hFF_B000
) (
    input  logic [AW-1:0]       addr,
    input  logic [N_CS-1:0]     en,
    output logic [NUM_INT-1:0]  int_raw,
    output logic [N_CS-1:0]     sel,
    output logic                ext_hit
);
    logic [N_CS-1:0] match;
    logic [N_CS-1:0] prio;

    // On-chip region flags.
    always_comb begin
        int_raw[0] = (addr <= 24'h01_FFFF);
        int_raw[1] = (addr >= RAM_BASE) && (addr <= 24'hFF_BFFF);
        int_raw[2] = (addr >= 24'hFF_E000);
    end

    genvar g;
    generate
        for (g = 0; g < N_CS; g++) begin : g_win
            assign match[g] = en[g] && win_hit(g, addr);
        end
    endgenerate

    // Fixed priority: the last matching index overrides earlier ones.
    always_comb begin
        prio = '0;
        for (int i = 0; i < N_CS; i++) begin
            if (match[i]) prio = N_CS'(1) << i;
        end
    end

    assign sel     = (|int_raw) ? '0 : prio;
    assign ext_hit = |sel;
endmodule

// File: rtl/csel_seq.sv
// Access sequencer: one strobe phase of wait+1 cycles per external
// access, or a single fault cycle for unmapped addresses. Start is only
// honoured while idle.
module csel_seq
    import csel_pkg::*;
#(
    parameter int WW = WAIT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ext_hit,
    input  logic [WW-1:0] wait_in,
    output logic          idle,
    output logic          xfer,
    output logic          fault,
    output logic          done
);
    seq_state_e    state;
    logic [WW-1:0] cnt;

    // State and wait-counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ext_hit ? ST_XFER : ST_FAULT;
                    cnt   <= wait_in;
                end
                ST_XFER: if (cnt == '0) state <= ST_IDLE;
                         else           cnt   <= cnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle  = (state == ST_IDLE);
    assign xfer  = (state == ST_XFER);
    assign fault = (state == ST_FAULT);
    assign done  = fault || (xfer && (cnt == '0));
endmodule

// File: rtl/csel_lane.sv
// Data lane steering for the external bus width: byte replication on
// 16-bit writes, low-lane zero-extended byte reads. Combinational.
module csel_lane
    import csel_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          w_wide,
    input  logic          w_word,
    input  logic [DW-1:0] wdata,
    input  logic          r_wide,
    input  logic          r_word,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] rdata
);
    localparam int HW = DW / 2;

    // Write lane pattern.
    always_comb begin
        if (!w_wide)     dout = {{HW{1'b0}}, wdata[HW-1:0]};
        else if (w_word) dout = wdata;
        else             dout = {wdata[HW-1:0], wdata[HW-1:0]};
    end

    // Read lane selection.
    always_comb begin
        if (r_wide && r_word) rdata = din;
        else                  rdata = {{HW{1'b0}}, din[HW-1:0]};
    end
endmodule

// File: rtl/csel_extbus_ctrl.sv
// External chip-select controller top. Decodes the CPU address, runs a
// wait-stated strobe on the chosen select and returns ready/bus error.
// Assumes cpu_req is a one-cycle pulse; requests during an access are
// dropped. Configuration is expected to be static during an access.
module csel_extbus_ctrl
    import csel_pkg::*;
#(
    parameter logic [23:0] RAM_BASE = 24'hFF_B000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [1:0]           cfg_field,
    input  logic [WAIT_W-1:0]    cfg_wdata,
    input  logic                 cpu_req,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_wr,
    input  logic                 cpu_word,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 cpu_ready,
    output logic                 bus_err,
    output logic [NUM_INT-1:0]   int_hit,
    output logic [NUM_CS-1:0]    ext_cs,
    output logic [ADDR_W-1:0]    ext_addr,
    output logic                 ext_rd,
    output logic                 ext_wr,
    output logic                 ext_doe,
    output logic [DATA_W-1:0]    ext_dout,
    input  logic [DATA_W-1:0]    ext_din
);
    logic [NUM_CS-1:0]        c_en, c_pol, c_wide;
    logic [NUM_CS*WAIT_W-1:0] c_wt;
    logic [NUM_INT-1:0]       int_raw;
    logic [NUM_CS-1:0]        dec_sel;
    logic                     dec_hit;
    logic [WAIT_W-1:0]        wait_live;
    logic                     wide_live;
    logic                     s_idle, s_xfer, s_fault, s_done;
    logic                     launch;
    logic [NUM_CS-1:0]        sel_q;
    logic [ADDR_W-1:0]        addr_q;
    logic                     wr_q, word_q, wide_q;
    logic [DATA_W-1:0]        dout_q, rdata_q;
    logic [DATA_W-1:0]        lane_dout, lane_rdata;
    logic [NUM_CS-1:0]        act;

    csel_cfg_bank #(.N_CS(NUM_CS), .WW(WAIT_W), .SW(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .field(cfg_field), .wdata(cfg_wdata),
        .en(c_en), .pol(c_pol), .wide(c_wide), .wt(c_wt)
    );

    csel_decode #(.N_CS(NUM_CS), .AW(ADDR_W), .RAM_BASE(RAM_BASE)) u_dec (
        .addr(cpu_addr), .en(c_en), .int_raw(int_raw),
        .sel(dec_sel), .ext_hit(dec_hit)
    );

    // Wait count and width of the winning select.
    always_comb begin
        wait_live = '0;
        wide_live = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (dec_sel[i]) begin
                wait_live = c_wt[i*WAIT_W +: WAIT_W];
                wide_live = c_wide[i];
            end
        end
    end

    csel_seq #(.WW(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(cpu_req && !(|int_raw)), .ext_hit(dec_hit),
        .wait_in(wait_live),
        .idle(s_idle), .xfer(s_xfer), .fault(s_fault), .done(s_done)
    );

    csel_lane #(.DW(DATA_W)) u_lane (
        .w_wide(wide_live), .w_word(cpu_word), .wdata(cpu_wdata),
        .r_wide(wide_q), .r_word(word_q), .din(ext_din),
        .dout(lane_dout), .rdata(lane_rdata)
    );

    assign launch = s_idle && cpu_req && dec_hit;

    // Hold the access attributes for the whole strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            addr_q <= '0;
            wr_q   <= 1'b0;
            word_q <= 1'b0;
            wide_q <= 1'b0;
            dout_q <= '0;
        end else if (launch) begin
            sel_q  <= dec_sel;
            addr_q <= cpu_addr;
            wr_q   <= cpu_wr;
            word_q <= cpu_word;
            wide_q <= wide_live;
            dout_q <= lane_dout;
        end
    end

    // Read data capture in the ready cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                           rdata_q <= '0;
        else if (s_xfer && s_done && !wr_q)   rdata_q <= lane_rdata;
    end

    assign act = s_xfer ? sel_q : '0;

    genvar g;
    generate
        for (g = 0; g < NUM_CS; g++) begin : g_pin
            assign ext_cs[g] = c_pol[g] ? act[g] : !act[g];
        end
    endgenerate

    assign int_hit   = cpu_req ? int_raw : '0;
    assign ext_addr  = addr_q;
    assign ext_rd    = s_xfer && !wr_q;
    assign ext_wr    = s_xfer && wr_q;
    assign ext_doe   = ext_wr;
    assign ext_dout  = ext_wr ? dout_q : '0;
    assign cpu_rdata = rdata_q;
    assign cpu_ready = s_done;
    assign bus_err   = s_fault;
endmodule

// File: rtl/csel_extbus_chk.sv
// Protocol checker for csel_extbus_ctrl, port-level only. Tracks the
// polarity bits itself from configuration writes to recover the
// active selects from the pins.
module csel_extbus_chk
    import csel_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [SEL_W-1:0]   cfg_sel,
    input logic [1:0]         cfg_field,
    input logic               cfg_bit,
    input logic               cpu_req,
    input logic               cpu_ready,
    input logic               bus_err,
    input logic [NUM_INT-1:0] int_hit,
    input logic [NUM_CS-1:0]  ext_cs,
    input logic [ADDR_W-1:0]  ext_addr,
    input logic               ext_rd,
    input logic               ext_wr,
    input logic [DATA_W-1:0]  ext_dout
);
    logic [NUM_CS-1:0] pol_sh;
    logic [NUM_CS-1:0] act;
    logic              strobe;

    // Polarity shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) pol_sh <= '0;
        else if (cfg_we && cfg_field == FLD_POL && int'(cfg_sel) < NUM_CS)
            pol_sh[cfg_sel] <= cfg_bit;
    end

    assign act    = ~(ext_cs ^ pol_sh);
    assign strobe = ext_rd || ext_wr;

    p_single_cs_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));
    p_strobe_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $onehot(act));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |->
            ($stable(ext_addr) && $stable(ext_cs) && $stable(ext_dout)));
    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    p_ready_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && strobe) |=> !strobe);
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (cpu_ready && !strobe));
    p_err_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);
    p_onchip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && (|int_hit) && !strobe && !bus_err) |=>
            (!strobe && !bus_err && !cpu_ready));
endmodule

bind csel_extbus_ctrl csel_extbus_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_bit(cfg_wdata[0]), .cpu_req(cpu_req),
    .cpu_ready(cpu_ready), .bus_err(bus_err), .int_hit(int_hit),
    .ext_cs(ext_cs), .ext_addr(ext_addr), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_dout(ext_dout)
);

// File: tb/sim_csel_extbus_ctrl.sv
module sim_csel_extbus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [1:0]  cfg_field = '0;
    logic [3:0]  cfg_wdata = '0;
    logic        cpu_req = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_word = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready, bus_err;
    logic [2:0]  int_hit;
    logic [5:0]  ext_cs;
    logic [23:0] ext_addr;
    logic        ext_rd, ext_wr, ext_doe;
    logic [15:0] ext_dout;
    logic [15:0] ext_din = '0;

    int nchk = 0;
    int nfail = 0;
    bit fin = 1'b0;

    // Bench-side model of the configuration.
    logic [5:0] m_en = '0, m_pol = '0, m_wide = '0;
    logic [3:0] m_wt [6] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF};

    csel_extbus_ctrl u0 (.*);

    always #10 clk = ~clk;

    // Vector: addr[63:40] wr[39] word[38] wdata[37:22] din[21:6] cs[5:3] (7=none) int[2:0]
    localparam int NV = 18;
    localparam logic [63:0] VEC [NV] = '{
        {24'h02_0000, 1'b0, 1'b1, 16'h0000, 16'hA1B2, 3'd0, 3'b000},
        {24'h90_0000, 1'b1, 1'b1, 16'h1234, 16'h0000, 3'd1, 3'b000},
        {24'hF1_0000, 1'b0, 1'b0, 16'h0000, 16'h55C3, 3'd2, 3'b000},
        {24'hFF_C100, 1'b1, 1'b0, 16'h00A7, 16'h0000, 3'd2, 3'b000},
        {24'hFF_D000, 1'b0, 1'b1, 16'h0000, 16'h9E7F, 3'd5, 3'b000},
        {24'hFF_9000, 1'b1, 1'b1, 16'hBEEF, 16'h0000, 3'd1, 3'b000},
        {24'h01_0000, 1'b0, 1'b1, 16'h0000, 16'h0000, 3'd7, 3'b001},
        {24'hFF_B800, 1'b0, 1'b1, 16'h0000, 16'h0000, 3'd7, 3'b010},
        {24'hFF_E100, 1'b1, 1'b1, 16'h0000, 16'h0000, 3'd7, 3'b100},
        {24'h7F_FFFF, 1'b1, 1'b0, 16'h003C, 16'h0000, 3'd0, 3'b000},
        {24'h80_0000, 1'b0, 1'b1, 16'h0000, 16'h4321, 3'd1, 3'b000},
        {24'hFF_7FFF, 1'b0, 1'b1, 16'h0000, 16'h1357, 3'd2, 3'b000},
        {24'hFF_C7FF, 1'b1, 1'b1, 16'h2468, 16'h0000, 3'd2, 3'b000},
        {24'hFF_C800, 1'b0, 1'b1, 16'h0000, 16'h0F0F, 3'd5, 3'b000},
        {24'hFF_AFFF, 1'b0, 1'b1, 16'h0000, 16'h8080, 3'd1, 3'b000},
        {24'h01_FFFF, 1'b0, 1'b1, 16'h0000, 16'h0000, 3'd7, 3'b001},
        {24'hFF_BFFF, 1'b0, 1'b1, 16'h0000, 16'h0000, 3'd7, 3'b010},
        {24'hFF_DFFF, 1'b1, 1'b1, 16'h1111, 16'h0000, 3'd5, 3'b000}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_field(input int sel, input int fld, input logic [3:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_field = 2'(fld); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (fld)
            0: m_en[sel]   = val[0];
            1: m_pol[sel]  = val[0];
            2: m_wide[sel] = val[0];
            default: m_wt[sel] = val;
        endcase
    endtask

    // One access; cs = expected select (7 none), err = expect bus error.
    // poke = raise a second request part-way through (R12).
    task automatic run_access(input logic [23:0] a, input bit wr, input bit word,
                              input logic [15:0] wd, input logic [15:0] din,
                              input int cs, input logic [2:0] exp_int,
                              input bit err, input bit poke);
        logic [5:0]  exp_pins;
        logic [15:0] exp_d;
        int n;
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_wr = wr; cpu_word = word;
        cpu_wdata = wd; ext_din = din;
        #1;
        check(int_hit == exp_int, "R1 int_hit", 32'(int_hit), 32'(exp_int));
        @(negedge clk);
        cpu_req = 1'b0;
        if (exp_int != 3'b000) begin
            check(!ext_rd && !ext_wr && !cpu_ready && !bus_err && ext_cs == ~m_pol,
                  "R1 no external access", {ext_rd, ext_wr, cpu_ready, bus_err, 2'b0, ext_cs},
                  {6'b0, ~m_pol});
            return;
        end
        if (err) begin
            check(bus_err && cpu_ready && !ext_rd && !ext_wr, "R10 bus error pulse",
                  {bus_err, cpu_ready, ext_rd, ext_wr}, 4'b1100);
            @(negedge clk);
            check(!bus_err && !cpu_ready, "R10 single cycle", {bus_err, cpu_ready}, 2'b00);
            return;
        end
        exp_pins = ~m_pol;
        exp_pins[cs] = m_pol[cs];
        if (!m_wide[cs])  exp_d = {8'h00, wd[7:0]};
        else if (word)    exp_d = wd;
        else              exp_d = {wd[7:0], wd[7:0]};
        if (wr) check(ext_wr && !ext_rd && ext_doe && ext_dout == exp_d, "R8 write lanes",
                      {ext_wr, ext_rd, ext_doe, ext_dout}, {3'b101, exp_d});
        else    check(ext_rd && !ext_wr && !ext_doe, "R6 read strobe",
                      {ext_rd, ext_wr, ext_doe}, 3'b100);
        check(ext_cs == exp_pins, "R2/R3/R5 chip select", 32'(ext_cs), 32'(exp_pins));
        n = 0;
        forever begin
            n++;
            if (ext_addr != a || ext_cs != exp_pins || !(ext_rd || ext_wr))
                check(1'b0, "R7 hold", 32'(ext_addr), 32'(a));
            if (cpu_ready || n > 20) break;
            if (poke && n == 3) begin
                cpu_req = 1'b1; cpu_addr = 24'hFF_D000; cpu_wr = ~wr;
            end
            @(negedge clk);
            cpu_req = 1'b0;
        end
        check(n == int'(m_wt[cs]) + 1, "R6 strobe length", 32'(n), 32'(int'(m_wt[cs]) + 1));
        @(negedge clk);
        check(!ext_rd && !ext_wr && !cpu_ready && ext_cs == ~m_pol, "R12/R6 idle after",
              {ext_rd, ext_wr, cpu_ready, 3'b0, ext_cs}, {9'b0, ~m_pol});
        if (!wr) begin
            exp_d = (m_wide[cs] && word) ? din : {8'h00, din[7:0]};
            check(cpu_rdata == exp_d, "R9 read data", 32'(cpu_rdata), 32'(exp_d));
        end
    endtask

    // Watchdog.
    initial begin
        #4_000_000;
        if (!fin) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state at the pins.
        check(ext_cs == 6'h3F && !ext_rd && !ext_wr && !cpu_ready && !bus_err
              && cpu_rdata == 16'h0, "R11 reset state", 32'(ext_cs), 32'h3F);
        // R10/R11: all disabled after reset -> bus error.
        run_access(24'h02_0000, 1'b0, 1'b1, 16'h0, 16'h0, 7, 3'b000, 1'b1, 1'b0);
        // R11 default wait 15, 8-bit; R12 poke during the access.
        set_field(0, 0, 4'h1);
        run_access(24'h02_0000, 1'b0, 1'b1, 16'h0, 16'hCAFE, 0, 3'b000, 1'b0, 1'b1);

        // Table configuration: all enabled, CS1/3/5 active high, CS0/2/4 wide.
        for (int i = 0; i < 6; i++) begin
            set_field(i, 0, 4'h1);
            set_field(i, 1, 4'(i % 2));
            set_field(i, 2, 4'((i + 1) % 2));
        end
        set_field(0, 3, 4'd2); set_field(1, 3, 4'd0); set_field(2, 3, 4'd3);
        set_field(3, 3, 4'd1); set_field(4, 3, 4'd5); set_field(5, 3, 4'd4);

        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            run_access(v[63:40], v[39], v[38], v[37:22], v[21:6],
                       int'(v[5:3]), v[2:0], 1'b0, 1'b0);
        end

        // R4: disabling higher selects exposes lower ones.
        set_field(5, 0, 4'h0);
        run_access(24'hFF_D000, 1'b0, 1'b1, 16'h0, 16'h9E7F, 4, 3'b000, 1'b0, 1'b0);
        set_field(4, 0, 4'h0); set_field(3, 0, 4'h0);
        run_access(24'hFF_D000, 1'b0, 1'b1, 16'h0, 16'h9E7F, 1, 3'b000, 1'b0, 1'b0);
        set_field(1, 0, 4'h0);
        run_access(24'hFF_D000, 1'b1, 1'b0, 16'h005A, 16'h0, 0, 3'b000, 1'b0, 1'b0);
        set_field(0, 0, 4'h0);
        run_access(24'hFF_D000, 1'b0, 1'b1, 16'h0, 16'h0, 7, 3'b000, 1'b1, 1'b0);
        // R4: CS2 still serves its own window with CS0/CS1 disabled.
        run_access(24'hF8_0000, 1'b0, 1'b0, 16'h0, 16'hABCD, 2, 3'b000, 1'b0, 1'b0);

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule